// File: doc/BRIEF.md
# SPI Command Slave for a Small Non-Volatile Store

This block is the serial front-end of a small non-volatile memory. An SPI master in mode 0 selects it by pulling the active-low select line low. The master then shifts in a one-byte command, an address where the command needs one, and data. The block deserializes the stream and turns each command into single-byte requests on a synchronous request/acknowledge port. A register-array memory, or the real store, sits on the other side of that port. Read data and a status byte are shifted back to the master on a serial output that has its own output enable, so several slaves can share the wire.

All SPI pins are brought into the system clock domain through two-flop synchronizers and sampled there. The serial clock must therefore run well below the system clock. The bench uses 16 system clocks per serial bit. A memory read request must be acknowledged within half a serial period so that the byte is ready for the next falling edge.

A transaction whose first byte is not a known command is treated as coming from a faulty master. Everything up to the next deselect is then ignored.

Top module: `spi_cmd_slave`

## Requirements
- R1: While the select input is high, the output enable stays low and activity on the data and serial clock inputs has no effect on requests, status or later transactions.
- R2: Input bits are taken on the rising serial clock edge, most significant bit first. The first byte after the select input falls is the command.
- R3: Output bits change on the falling serial clock edge, most significant bit first. For a read, the first data bit is driven on the falling edge right after the last address bit is taken in.
- R4: The command codes are 0x03 read, 0x02 write, 0x20 sector erase, 0x05 read status and 0x06 write enable. Every other value is illegal.
- R5: After an illegal command, the block issues no memory request and keeps the output enable low until the select input rises. The next transaction then behaves normally.
- R6: A read takes a 16-bit address (high byte first) and returns bytes from consecutive addresses for as long as the master keeps clocking.
- R7: A write takes a 16-bit address and issues one write request per complete data byte at consecutive addresses. A partial trailing byte is discarded, and without the write-enable latch set no write request is issued.
- R8: A sector erase takes a 16-bit address and issues one erase request carrying it, but only when the write-enable latch is set.
- R9: The status byte has bit 0 = memory busy, bit 1 = write-enable latch, and the other bits 0. It is reloaded at the start of each status byte, so the master may read it repeatedly.
- R10: Command 0x06 sets the write-enable latch. The latch is cleared when the select input rises at the end of an accepted write or erase.
- R11: A memory request holds its operation (0 read, 1 write, 2 erase), address and write data stable until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sck | input | 1 | Serial clock from the master |
| ncs | input | 1 | Active-low slave select |
| si | input | 1 | Serial data from the master |
| so | output | 1 | Serial data to the master |
| so_oe | output | 1 | Output enable for `so`; low means high impedance |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_op | output | 2 | Request kind: 0 read, 1 write, 2 erase |
| mem_addr | output | ADDR_W | Request address |
| mem_wdata | output | 8 | Write data |
| mem_ack | input | 1 | One-cycle acknowledge from the memory |
| mem_rdata | input | 8 | Read data, valid with `mem_ack` |
| mem_busy | input | 1 | Memory busy flag reported in status |

## Verification
Data bytes such as 0xA5 and 0x3C, and an erase pattern of 0xFF, are chosen so that bit-order or shift-off-by-one faults give visibly different values. Reads of written and untouched locations tell apart correct address increment and a stuck address. The write-enable latch is tried with and without its set command, so the gate and the clear-on-deselect both show up. Illegal commands followed by a well-formed read are compared with the same read alone, to separate lockout from plain decoding. Toggling the serial clock while the block is deselected shows whether select gating works.

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              ncs,
  input  logic              si,
  output logic              so,
  output logic              so_oe,
  output logic              mem_req,
  output logic [1:0]        mem_op,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_ack,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_busy
);
  localparam int AB  = ADDR_W / 8;
  localparam int ACW = (AB > 1) ? $clog2(AB) : 1;
  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_ER = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_OPC, S_ADDR, S_RD, S_WR, S_STAT, S_SKIP, S_LOCK} st_t;

  st_t state;
  logic [2:0] sck_q, ncs_q;
  logic [1:0] si_q;
  logic [7:0] sh, rbuf;
  logic [2:0] bitcnt;
  logic [ACW-1:0] acnt;
  logic [ADDR_W-1:0] addr;
  logic [1:0] cmd;
  logic wel, dirty, so_r;

  wire sck_rise = sck_q[1] & ~sck_q[2];
  wire sck_fall = ~sck_q[1] & sck_q[2];
  wire ncs_fall = ~ncs_q[1] & ncs_q[2];
  wire ncs_rise = ncs_q[1] & ~ncs_q[2];
  wire [7:0] sh_nx = {sh[6:0], si_q[1]};
  wire [ADDR_W+7:0] acat = {addr, sh_nx};
  wire [ADDR_W-1:0] addr_nx = acat[ADDR_W-1:0];
  wire [7:0] status = {6'd0, wel, mem_busy};
  wire active = (state != S_IDLE) && (state != S_LOCK);

  assign so_oe = (state == S_RD) || (state == S_STAT);
  assign so    = so_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q <= '0; ncs_q <= '1; si_q <= '0;
      state <= S_IDLE; sh <= '0; rbuf <= '0; bitcnt <= '0; acnt <= '0;
      addr <= '0; cmd <= OP_RD; wel <= 1'b0; dirty <= 1'b0; so_r <= 1'b0;
      mem_req <= 1'b0; mem_op <= OP_RD; mem_addr <= '0; mem_wdata <= '0;
    end else begin
      sck_q <= {sck_q[1:0], sck};
      ncs_q <= {ncs_q[1:0], ncs};
      si_q  <= {si_q[0], si};
      if (mem_req && mem_ack) begin
        mem_req <= 1'b0;
        if (mem_op == OP_RD) rbuf <= mem_rdata;
      end
      if (ncs_rise) begin
        state <= S_IDLE;
        if (dirty) wel <= 1'b0;
        dirty <= 1'b0;
      end else if (ncs_fall) begin
        state <= S_OPC; bitcnt <= '0; acnt <= '0;
      end else if (active) begin
        if (sck_rise) begin
          sh <= sh_nx;
          bitcnt <= bitcnt + 3'd1;
          if (bitcnt == 3'd7) begin
            case (state)
              S_OPC: case (sh_nx)
                8'h03: begin state <= S_ADDR; cmd <= OP_RD; end
                8'h02: if (wel) begin state <= S_ADDR; cmd <= OP_WR; dirty <= 1'b1; end
                       else state <= S_SKIP;
                8'h20: if (wel) begin state <= S_ADDR; cmd <= OP_ER; dirty <= 1'b1; end
                       else state <= S_SKIP;
                8'h05: begin state <= S_STAT; rbuf <= status; end
                8'h06: begin wel <= 1'b1; state <= S_SKIP; end
                default: state <= S_LOCK;
              endcase
              S_ADDR: begin
                addr <= addr_nx;
                acnt <= acnt + 1'b1;
                if (acnt == ACW'(AB - 1)) begin
                  case (cmd)
                    OP_RD: begin
                      state <= S_RD;
                      mem_req <= 1'b1; mem_op <= OP_RD; mem_addr <= addr_nx;
                    end
                    OP_WR: state <= S_WR;
                    default: begin
                      state <= S_SKIP;
                      mem_req <= 1'b1; mem_op <= OP_ER; mem_addr <= addr_nx;
                    end
                  endcase
                end
              end
              S_RD: begin
                addr <= addr + 1'b1;
                mem_req <= 1'b1; mem_op <= OP_RD; mem_addr <= addr + 1'b1;
              end
              S_WR: begin
                addr <= addr + 1'b1;
                mem_req <= 1'b1; mem_op <= OP_WR; mem_addr <= addr; mem_wdata <= sh_nx;
              end
              S_STAT: rbuf <= status;
              default: ;
            endcase
          end
        end
        if (sck_fall && so_oe) so_r <= rbuf[3'd7 - bitcnt];
      end
    end
  end

  // R1
  idle_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ncs_q[2] && ncs_q[1]) |-> !so_oe);

  // R5
  lock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LOCK) |-> (!mem_req && !so_oe));

  // R7
  wel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_req) && mem_op != OP_RD) |-> wel);

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_op) && $stable(mem_wdata)));

  // R1
  oe_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> !ncs_q[2]);
endmodule

// File: tb/sim_spi_cmd_slave.sv
module sim_spi_cmd_slave;
  localparam int HALF = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, ncs = 1'b1, si = 1'b0;
  logic so, so_oe, mem_req, mem_ack = 1'b0, mem_busy = 1'b0;
  logic [1:0] mem_op;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic [7:0] mem [256];
  int tests = 0, fails = 0, n_rd = 0, n_wr = 0, n_er = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spi_cmd_slave u0 (.clk, .rst_n, .sck, .ncs, .si, .so, .so_oe, .mem_req, .mem_op,
    .mem_addr, .mem_wdata, .mem_ack, .mem_rdata, .mem_busy);

  assign mem_rdata = mem[mem_addr[7:0]];

  initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h55;

  always @(posedge clk) begin
    mem_ack <= mem_req && !mem_ack;
    if (mem_req && mem_ack) begin
      case (mem_op)
        2'd0: n_rd++;
        2'd1: begin n_wr++; mem[mem_addr[7:0]] <= mem_wdata; end
        default: begin
          n_er++;
          for (int i = 0; i < 16; i++) mem[{mem_addr[7:4], 4'(i)}] <= 8'hFF;
        end
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx,
                       output bit oe_all, output bit oe_any);
    oe_all = 1'b1; oe_any = 1'b0; rx = '0;
    for (int i = 7; i >= 8 - n; i--) begin
      @(negedge clk); si = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = so; oe_all &= so_oe; oe_any |= so_oe;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, output bit oe_all, output bit oe_any);
    xbits(tx, 8, rx, oe_all, oe_any);
  endtask

  task automatic sel;
    @(negedge clk); ncs = 1'b0; repeat (4) @(negedge clk);
  endtask

  task automatic desel;
    repeat (4) @(negedge clk); ncs = 1'b1; repeat (8) @(negedge clk);
  endtask

  task automatic read_status(output logic [7:0] st, output bit oe);
    logic [7:0] rx; bit a, b;
    sel; xbyte(8'h05, rx, a, b); xbyte(8'h00, st, oe, b); desel;
  endtask

  task automatic wren;
    logic [7:0] rx; bit a, b;
    sel; xbyte(8'h06, rx, a, b); desel;
  endtask

  task automatic t_reset;
    chk(!so_oe, "R1 reset oe", so_oe, 0);
    chk(!mem_req, "R11 reset req", mem_req, 0);
  endtask

  task automatic t_ignore_deselected;
    logic [7:0] rx, st; bit a, b; int r0;
    r0 = n_rd + n_wr + n_er;
    xbyte(8'h06, rx, a, b);
    xbyte(8'h03, rx, a, b);
    chk(!b, "R1 oe while deselected", b, 0);
    chk(n_rd + n_wr + n_er == r0, "R1 no request while deselected", n_rd + n_wr + n_er, r0);
    read_status(st, a);
    chk(st == 8'h00, "R1 latch untouched by deselected clocks", st, 8'h00);
  endtask

  task automatic t_status;
    logic [7:0] st, rx, s2; bit oe, b;
    mem_busy = 1'b1;
    read_status(st, oe);
    chk(st == 8'h01 && oe, "R9 status busy", {oe, st}, 9'h101);
    wren;
    sel; xbyte(8'h05, rx, oe, b); xbyte(8'h00, st, oe, b); xbyte(8'h00, s2, b, b); desel;
    chk(st == 8'h03, "R10 latch set by 0x06", st, 8'h03);
    chk(s2 == 8'h03, "R9 repeated status byte", s2, 8'h03);
    mem_busy = 1'b0;
    read_status(st, oe);
    chk(st == 8'h02, "R9 busy cleared, latch kept", st, 8'h02);
  endtask

  task automatic t_write;
    logic [7:0] rx, st; bit a, b; int w0;
    logic [7:0] keep;
    keep = mem[8'h12];
    w0 = n_wr;
    sel;
    xbyte(8'h02, rx, a, b); xbyte(8'h00, rx, a, b); xbyte(8'h10, rx, a, b);
    xbyte(8'hA5, rx, a, b); xbyte(8'h3C, rx, a, b); xbits(8'hF0, 4, rx, a, b);
    desel;
    chk(n_wr - w0 == 2, "R7 full bytes only", n_wr - w0, 2);
    chk(mem[8'h10] == 8'hA5, "R7 first byte MSB first (R2)", mem[8'h10], 8'hA5);
    chk(mem[8'h11] == 8'h3C, "R7 auto-increment", mem[8'h11], 8'h3C);
    chk(mem[8'h12] == keep, "R7 partial byte discarded", mem[8'h12], keep);
    read_status(st, a);
    chk(st == 8'h00, "R10 latch cleared after write", st, 8'h00);
    w0 = n_wr;
    sel;
    xbyte(8'h02, rx, a, b); xbyte(8'h00, rx, a, b); xbyte(8'h30, rx, a, b); xbyte(8'h77, rx, a, b);
    desel;
    chk(n_wr == w0, "R7 write refused without latch", n_wr - w0, 0);
  endtask

  task automatic t_read(input logic [15:0] ad, input logic [7:0] e0, input logic [7:0] e1);
    logic [7:0] rx, d0, d1; bit a, b, oe0, oe1;
    sel;
    xbyte(8'h03, rx, a, b);
    xbyte(ad[15:8], rx, a, b);
    xbyte(ad[7:0], rx, a, b);
    chk(!b, "R3 oe low before data", b, 0);
    xbyte(8'h00, d0, oe0, b); xbyte(8'h00, d1, oe1, b);
    desel;
    chk(d0 == e0 && oe0, "R3 first read byte", d0, e0);
    chk(d1 == e1 && oe1, "R6 next address byte", d1, e1);
    chk(!so_oe, "R1 oe low after deselect", so_oe, 0);
  endtask

  task automatic t_illegal;
    logic [7:0] rx, st; bit a, b, any; int r0;
    r0 = n_rd + n_wr + n_er;
    any = 1'b0;
    sel;
    xbyte(8'h9F, rx, a, b); any |= b;
    xbyte(8'h03, rx, a, b); any |= b;
    xbyte(8'h00, rx, a, b); any |= b;
    xbyte(8'h10, rx, a, b); any |= b;
    xbyte(8'h00, rx, a, b); any |= b;
    desel;
    chk(n_rd + n_wr + n_er == r0, "R5 no request after illegal code", n_rd + n_wr + n_er - r0, 0);
    chk(!any, "R5 output stays tri-stated", any, 0);
    sel; xbyte(8'h01, rx, a, b); any = b; xbyte(8'h05, rx, a, b); any |= b; desel;
    chk(!any, "R4 0x01 is illegal", any, 0);
    read_status(st, a);
    chk(st == 8'h00 && a, "R5 next transaction normal", {a, st}, 9'h100);
  endtask

  task automatic t_erase;
    logic [7:0] rx, st; bit a, b; int e0;
    e0 = n_er;
    sel; xbyte(8'h20, rx, a, b); xbyte(8'h00, rx, a, b); xbyte(8'h43, rx, a, b); desel;
    chk(n_er == e0, "R8 erase refused without latch", n_er - e0, 0);
    wren;
    sel; xbyte(8'h20, rx, a, b); xbyte(8'h00, rx, a, b); xbyte(8'h43, rx, a, b); desel;
    chk(n_er - e0 == 1, "R8 one erase request", n_er - e0, 1);
    chk(mem[8'h40] == 8'hFF && mem[8'h4F] == 8'hFF, "R8 sector erased", mem[8'h4F], 8'hFF);
    read_status(st, a);
    chk(st == 8'h00, "R10 latch cleared after erase", st, 8'h00);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_ignore_deselected;
    t_status;
    wren;
    t_write;
    t_read(16'h0010, 8'hA5, 8'h3C);
    t_read(16'h0020, 8'h20 ^ 8'h55, 8'h21 ^ 8'h55);
    t_illegal;
    t_erase;
    t_read(16'h004E, 8'hFF, 8'hFF);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule